// File: doc/BRIEF.md
# Hall-Timed Speed Regulator with Shaped Current Demand

This block closes the outer speed loop of a single-phase-fed brushless motor drive. It times the interval between successive changes on the three rotor-position sensor lines and turns that interval into a speed figure. It subtracts the figure from a commanded speed and runs a proportional-integral law on the difference. The result is a non-negative current magnitude. A shaping stage then forms the demand handed to the inner current modulator. The demand is either the magnitude itself, the magnitude scaled by the sampled rectified bus voltage, or the magnitude scaled by the square of that voltage. The first gives a square-wave line current and the other two give progressively more sinusoidal line currents.

The integrator update is paced by an external sample strobe. The shaping stage runs every clock, so the demand follows the bus waveform continuously between updates. The bus voltage is an unsigned fraction in which all-ones is just below 1.0.

Top module: `speedLoop`

## Requirements
- R1: After reset, `curRef` reads 0 and stays 0 until the first `sampleStrobe`.
- R2: Measured speed equals floor(SPEED_NUM / N), where N is the number of clock cycles between two successive changes of `hallIn`, limited to 2^SPD_W-1. The first change after reset or after a stall produces no measurement.
- R3: When `hallIn` has not changed for TIMEOUT_CYC cycles, the measured speed becomes 0 and stays 0 until a new interval has been timed.
- R4: On each cycle with `sampleStrobe` high, the integrator takes integ + KI*(speedSet - speed), clamped to [INT_MIN, INT_MAX]. The magnitude becomes (KP*(speedSet - speed) + new integ) shifted arithmetically right by GAIN_SH.
- R5: The magnitude is saturated to the range 0 to 2^MAG_W-1. A negative result gives 0.
- R6: With `shapeSel` = 0 (flat), or with the unused code 3, `curRef` equals the magnitude.
- R7: With `shapeSel` = 1 (linear), `curRef` = (mag*v + 2^(V_W-1)) >> V_W, where v is `busVolt`.
- R8: With `shapeSel` = 2 (square), first vsq = (v*v + 2^(V_W-1)) >> V_W, then `curRef` = (mag*vsq + 2^(V_W-1)) >> V_W.
- R9: Without `sampleStrobe`, the magnitude holds its value whatever `hallIn` or `busVolt` do.
- R10: A change on `busVolt`, `shapeSel` or the magnitude reaches `curRef` after exactly two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hallIn | input | 3 | Rotor position sensor lines, asynchronous |
| speedSet | input | SPD_W | Commanded speed, same scale as the measured speed |
| busVolt | input | V_W | Sampled rectified bus voltage, unsigned fraction |
| shapeSel | input | 2 | 0 flat, 1 linear, 2 square, 3 treated as flat |
| sampleStrobe | input | 1 | One-cycle pulse that advances the PI law |
| curRef | output | MAG_W | Current demand for the inner modulator |

## Verification
A corrupted integrator or a wrong period count stays hidden until the next sample strobe. Two edges after that strobe it shows up as a wrong `curRef` in flat mode, so each strobe acts as a sampling point for the loop state. Errors in the shaping pipeline show within two edges of a bus-voltage step, with no strobe needed. A speed register that fails to clear on a stall shows as a too-small demand at the first strobe after the timeout.

// File: rtl/speedLoopPkg.sv
package speedLoopPkg;

  typedef enum logic [1:0] {
    SHAPE_FLAT = 2'd0,
    SHAPE_LIN  = 2'd1,
    SHAPE_SQR  = 2'd2,
    SHAPE_RSV  = 2'd3
  } shapeMode_e;

  // strobes from the timing control into the loop datapath
  typedef struct packed {
    logic startDiv;
    logic clearSpeed;
    logic piStep;
  } loopStrobe_t;

endpackage

// File: rtl/hallTimer.sv
module hallTimer
  import speedLoopPkg::*;
#(
  parameter int TIMEOUT_CYC = 20000,
  parameter int CNT_W       = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       hallIn,
  input  logic             sampleStrobe,
  output loopStrobe_t      strobes,
  output logic [CNT_W-1:0] period
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC);

  logic [2:0]       hallMeta, hallSync, hallPrev;
  logic [1:0]       warmUp;
  logic             primed, haveRef, hallEdge, timedOut;
  logic [CNT_W-1:0] cnt;

  assign primed   = (warmUp == 2'd3);
  assign hallEdge = primed && (hallSync != hallPrev);
  assign timedOut = (cnt == LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hallMeta <= '0;
      hallSync <= '0;
      hallPrev <= '0;
      warmUp   <= '0;
      haveRef  <= 1'b0;
      cnt      <= '0;
    end else begin
      hallMeta <= hallIn;
      hallSync <= hallMeta;
      hallPrev <= hallSync;
      if (!primed) warmUp <= warmUp + 2'd1;
      if (hallEdge) begin
        cnt     <= '0;
        haveRef <= 1'b1;
      end else if (timedOut) begin
        haveRef <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign period             = cnt + 1'b1;
  assign strobes.startDiv   = hallEdge && haveRef && !timedOut;
  assign strobes.clearSpeed = timedOut;
  assign strobes.piStep     = sampleStrobe;

endmodule

// File: rtl/loopDatapath.sv
module loopDatapath
  import speedLoopPkg::*;
#(
  parameter int SPEED_NUM = 1000000,
  parameter int CNT_W     = 15,
  parameter int SPD_W     = 12,
  parameter int MAG_W     = 12,
  parameter int KP        = 4,
  parameter int KI        = 1,
  parameter int GAIN_SH   = 4,
  parameter int INT_W     = 24,
  parameter int INT_MIN   = 0,
  parameter int INT_MAX   = 65535
) (
  input  logic             clk,
  input  logic             rst_n,
  input  loopStrobe_t      strobes,
  input  logic [CNT_W-1:0] period,
  input  logic [SPD_W-1:0] speedSet,
  output logic [SPD_W-1:0] speed,
  output logic [MAG_W-1:0] magnitude
);

  localparam int NUM_W   = $clog2(SPEED_NUM + 1);
  localparam int STEP_W  = $clog2(NUM_W + 1);
  localparam int SPD_MAX = (1 << SPD_W) - 1;
  localparam int ACC_W   = INT_W + 2;
  localparam logic signed [ACC_W-1:0] KP_S    = ACC_W'(KP);
  localparam logic signed [ACC_W-1:0] KI_S    = ACC_W'(KI);
  localparam logic signed [ACC_W-1:0] LO_S    = ACC_W'(INT_MIN);
  localparam logic signed [ACC_W-1:0] HI_S    = ACC_W'(INT_MAX);
  localparam logic signed [ACC_W-1:0] MAGMX_S = ACC_W'((1 << MAG_W) - 1);

  // serial restoring divider: SPEED_NUM / period
  logic [NUM_W-1:0]  numSh, quo, quoNext;
  logic [CNT_W:0]    rem, trial, remNext;
  logic [CNT_W-1:0]  den;
  logic [STEP_W-1:0] stepLeft;
  logic              busy, fits;
  logic [SPD_W-1:0]  speedSat;

  assign trial    = {rem[CNT_W-1:0], numSh[NUM_W-1]};
  assign fits     = trial >= {1'b0, den};
  assign remNext  = fits ? (trial - {1'b0, den}) : trial;
  assign quoNext  = {quo[NUM_W-2:0], fits};
  assign speedSat = (quoNext > NUM_W'(SPD_MAX)) ? SPD_W'(SPD_MAX) : quoNext[SPD_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      numSh    <= '0;
      quo      <= '0;
      rem      <= '0;
      den      <= '0;
      stepLeft <= '0;
      speed    <= '0;
    end else if (strobes.clearSpeed) begin
      busy  <= 1'b0;
      speed <= '0;
    end else if (strobes.startDiv) begin
      busy     <= 1'b1;
      numSh    <= NUM_W'(SPEED_NUM);
      quo      <= '0;
      rem      <= '0;
      den      <= period;
      stepLeft <= STEP_W'(NUM_W);
    end else if (busy) begin
      numSh    <= numSh << 1;
      quo      <= quoNext;
      rem      <= remNext;
      stepLeft <= stepLeft - 1'b1;
      if (stepLeft == STEP_W'(1)) begin
        busy  <= 1'b0;
        speed <= speedSat;
      end
    end
  end

  // proportional-integral law
  logic signed [SPD_W:0]       err;
  logic signed [ACC_W-1:0]     errW, integW, integSum, integNext, piSum, piShift;
  logic signed [INT_W-1:0]     integ;
  logic        [MAG_W-1:0]     magNext;

  assign err       = $signed({1'b0, speedSet}) - $signed({1'b0, speed});
  assign errW      = ACC_W'(err);
  assign integW    = ACC_W'(integ);
  assign integSum  = integW + KI_S * errW;
  assign integNext = (integSum > HI_S) ? HI_S : ((integSum < LO_S) ? LO_S : integSum);
  assign piSum     = KP_S * errW + integNext;
  assign piShift   = piSum >>> GAIN_SH;

  always_comb begin
    if (piShift < 0)             magNext = '0;
    else if (piShift > MAGMX_S)  magNext = '1;
    else                         magNext = piShift[MAG_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      integ     <= '0;
      magnitude <= '0;
    end else if (strobes.piStep) begin
      integ     <= integNext[INT_W-1:0];
      magnitude <= magNext;
    end
  end

endmodule

// File: rtl/refShaper.sv
module refShaper
  import speedLoopPkg::*;
#(
  parameter int MAG_W = 12,
  parameter int V_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAG_W-1:0] magnitude,
  input  logic [V_W-1:0]   busVolt,
  input  logic [1:0]       shapeSel,
  output logic [MAG_W-1:0] curRef
);

  localparam int PM_W = MAG_W + V_W + 1;
  localparam int PV_W = 2 * V_W + 1;

  function automatic logic [MAG_W-1:0] scaleMag(input logic [MAG_W-1:0] a,
                                                input logic [V_W-1:0] b);
    logic [PM_W-1:0] p;
    p = PM_W'(a) * PM_W'(b) + PM_W'(1 << (V_W - 1));
    p = p >> V_W;
    return (p > PM_W'((1 << MAG_W) - 1)) ? '1 : p[MAG_W-1:0];
  endfunction

  function automatic logic [V_W-1:0] squareV(input logic [V_W-1:0] b);
    logic [PV_W-1:0] p;
    p = PV_W'(b) * PV_W'(b) + PV_W'(1 << (V_W - 1));
    p = p >> V_W;
    return (p > PV_W'((1 << V_W) - 1)) ? '1 : p[V_W-1:0];
  endfunction

  logic [MAG_W-1:0] magReg;
  logic [V_W-1:0]   vReg, vSqReg;
  shapeMode_e       modeReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      magReg  <= '0;
      vReg    <= '0;
      vSqReg  <= '0;
      modeReg <= SHAPE_FLAT;
      curRef  <= '0;
    end else begin
      magReg  <= magnitude;
      vReg    <= busVolt;
      vSqReg  <= squareV(busVolt);
      modeReg <= shapeMode_e'(shapeSel);
      case (modeReg)
        SHAPE_LIN: curRef <= scaleMag(magReg, vReg);
        SHAPE_SQR: curRef <= scaleMag(magReg, vSqReg);
        default:   curRef <= magReg;
      endcase
    end
  end

endmodule

// File: rtl/speedLoop.sv
module speedLoop
  import speedLoopPkg::*;
#(
  parameter int SPEED_NUM   = 1000000,
  parameter int TIMEOUT_CYC = 20000,
  parameter int SPD_W       = 12,
  parameter int MAG_W       = 12,
  parameter int V_W         = 8,
  parameter int KP          = 4,
  parameter int KI          = 1,
  parameter int GAIN_SH     = 4,
  parameter int INT_W       = 24,
  parameter int INT_MIN     = 0,
  parameter int INT_MAX     = 65535
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       hallIn,
  input  logic [SPD_W-1:0] speedSet,
  input  logic [V_W-1:0]   busVolt,
  input  logic [1:0]       shapeSel,
  input  logic             sampleStrobe,
  output logic [MAG_W-1:0] curRef
);

  localparam int CNT_W = $clog2(TIMEOUT_CYC + 2);

  loopStrobe_t      strobes;
  logic [CNT_W-1:0] period;
  logic [SPD_W-1:0] speed;
  logic [MAG_W-1:0] magnitude;

  hallTimer #(.TIMEOUT_CYC(TIMEOUT_CYC), .CNT_W(CNT_W)) timerU (
    .clk(clk), .rst_n(rst_n), .hallIn(hallIn), .sampleStrobe(sampleStrobe),
    .strobes(strobes), .period(period)
  );

  loopDatapath #(
    .SPEED_NUM(SPEED_NUM), .CNT_W(CNT_W), .SPD_W(SPD_W), .MAG_W(MAG_W),
    .KP(KP), .KI(KI), .GAIN_SH(GAIN_SH), .INT_W(INT_W),
    .INT_MIN(INT_MIN), .INT_MAX(INT_MAX)
  ) pathU (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .period(period),
    .speedSet(speedSet), .speed(speed), .magnitude(magnitude)
  );

  refShaper #(.MAG_W(MAG_W), .V_W(V_W)) shapeU (
    .clk(clk), .rst_n(rst_n), .magnitude(magnitude), .busVolt(busVolt),
    .shapeSel(shapeSel), .curRef(curRef)
  );

endmodule

// File: rtl/speedLoopChk.sv
module speedLoopChk #(
  parameter int TIMEOUT_CYC = 20000,
  parameter int SPD_W       = 12,
  parameter int MAG_W       = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       hallIn,
  input logic             sampleStrobe,
  input logic [1:0]       shapeSel,
  input logic [SPD_W-1:0] speed,
  input logic [MAG_W-1:0] magnitude,
  input logic [MAG_W-1:0] curRef
);

  localparam int IDLE_W   = $clog2(TIMEOUT_CYC + 16) + 1;
  localparam logic [IDLE_W-1:0] IDLE_LIM = IDLE_W'(TIMEOUT_CYC + 4);

  logic [1:0]        age;
  logic [IDLE_W-1:0] idle;
  logic [2:0]        hallLast;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age      <= '0;
      idle     <= '0;
      hallLast <= hallIn;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      hallLast <= hallIn;
      if (hallIn != hallLast) idle <= '0;
      else if (idle <= IDLE_LIM) idle <= idle + 1'b1;
    end
  end

  // R9: magnitude only moves on a strobe
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !$past(sampleStrobe)) |-> $stable(magnitude));

  // R6: flat and unused codes pass the magnitude two edges later (R10 timing)
  assert_flat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && ($past(shapeSel, 2) == 2'd0 || $past(shapeSel, 2) == 2'd3))
      |-> curRef == $past(magnitude, 2));

  // R7 and R8: a fraction below one never raises the demand
  assert_no_gain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> curRef <= $past(magnitude, 2));

  // R3: a stalled rotor reads as zero speed
  assert_stall_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle > IDLE_LIM) |-> speed == '0);

  // R1: nothing but a strobe lifts the magnitude off zero after reset
  assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd1) |-> magnitude == '0);

endmodule

bind speedLoop speedLoopChk #(
  .TIMEOUT_CYC(TIMEOUT_CYC), .SPD_W(SPD_W), .MAG_W(MAG_W)
) chkU (
  .clk(clk), .rst_n(rst_n), .hallIn(hallIn), .sampleStrobe(sampleStrobe),
  .shapeSel(shapeSel), .speed(speed), .magnitude(magnitude), .curRef(curRef)
);

// File: tb/tb_speedLoop.sv
module tb_speedLoop;

  localparam int TOUT = 3000;
  localparam int KPV = 4, KIV = 2, SHV = 4;
  localparam int IMIN = -4096, IMAX = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  hallIn = 3'b001;
  logic [11:0] speedSet = '0;
  logic [7:0]  busVolt = '0;
  logic [1:0]  shapeSel = '0;
  logic        sampleStrobe = 1'b0;
  logic [11:0] curRef;

  int checks = 0, errors = 0;
  int hallPer = 0;
  int integM = 0, magM = 0;

  always #2 clk = ~clk;

  speedLoop #(
    .TIMEOUT_CYC(TOUT), .KP(KPV), .KI(KIV), .GAIN_SH(SHV),
    .INT_MIN(IMIN), .INT_MAX(IMAX)
  ) dut (
    .clk(clk), .rst_n(rst_n), .hallIn(hallIn), .speedSet(speedSet),
    .busVolt(busVolt), .shapeSel(shapeSel), .sampleStrobe(sampleStrobe),
    .curRef(curRef)
  );

  typedef struct packed { int per; int set; int mode; int v; } vec_t;
  localparam vec_t VECS [10] = '{
    '{1000, 1500, 0, 200}, '{1000, 1500, 1, 200}, '{500, 1000, 2, 180},
    '{500, 2500, 2, 255},  '{244, 4095, 0, 128},  '{245, 4095, 3, 100},
    '{2000, 800, 1, 64},   '{0, 600, 1, 255},     '{1250, 300, 0, 10},
    '{400, 3000, 2, 90}
  };

  // six-step position sensor pattern
  initial begin
    int idx = 0;
    forever begin
      if (hallPer == 0) @(negedge clk);
      else begin
        repeat (hallPer) @(negedge clk);
        idx = (idx + 1) % 6;
        case (idx)
          0: hallIn = 3'b001; 1: hallIn = 3'b011; 2: hallIn = 3'b010;
          3: hallIn = 3'b110; 4: hallIn = 3'b100; default: hallIn = 3'b101;
        endcase
      end
    end
  end

  function automatic int speedOf(input int per);
    if (per == 0) return 0;
    return (1000000 / per > 4095) ? 4095 : 1000000 / per;
  endfunction

  function automatic int shapeOf(input int m, input int v, input int mode);
    int vs;
    case (mode)
      1: return (m * v + 128) >> 8;
      2: begin vs = (v * v + 128) >> 8; return (m * vs + 128) >> 8; end
      default: return m;
    endcase
  endfunction

  task automatic piModel(input int setv, input int spd);
    int e, acc;
    e = setv - spd;
    integM = integM + KIV * e;
    if (integM > IMAX) integM = IMAX;
    if (integM < IMIN) integM = IMIN;
    acc = (KPV * e + integM) >>> SHV;
    magM = (acc < 0) ? 0 : ((acc > 4095) ? 4095 : acc);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic strobe(input int spd);
    @(negedge clk) sampleStrobe = 1'b1;
    @(negedge clk) sampleStrobe = 1'b0;
    piModel(int'(speedSet), spd);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset demand", int'(curRef), 0);
    busVolt = 8'd255; shapeSel = 2'd0; hallPer = 300;
    repeat (2500) @(negedge clk);
    check("R1 no strobe yet", int'(curRef), 0);

    for (int i = 0; i < 10; i++) begin
      string tag;
      hallPer  = VECS[i].per;
      speedSet = 12'(VECS[i].set);
      shapeSel = 2'(VECS[i].mode);
      busVolt  = 8'(VECS[i].v);
      repeat ((VECS[i].per == 0) ? TOUT + 2500 : 6 * VECS[i].per + 200) @(negedge clk);
      strobe(speedOf(VECS[i].per));
      tag = (VECS[i].mode == 1) ? "R7" : ((VECS[i].mode == 2) ? "R8" : "R6");
      if (VECS[i].per == 0) tag = {tag, " R3"};
      check($sformatf("R2 R4 R5 %s vector %0d", tag, i), int'(curRef),
            shapeOf(magM, VECS[i].v, VECS[i].mode));
    end

    // R4: integrator climbs into its upper clamp
    hallPer = 700; shapeSel = 2'd0; speedSet = 12'd4095;
    repeat (4400) @(negedge clk);
    for (int k = 0; k < 8; k++) strobe(1428);
    check("R4 upper integrator clamp", int'(curRef), 1916);
    check("R4 model agreement", int'(curRef), magM);

    // R9: hall rate and bus voltage change, no strobe
    hallPer = 900; busVolt = 8'd17;
    repeat (6000) @(negedge clk);
    check("R9 magnitude held", int'(curRef), 1916);

    // R10: two-edge latency of the bus voltage path
    shapeSel = 2'd1; busVolt = 8'd0;
    repeat (4) @(negedge clk);
    check("R7 zero bus gives zero demand", int'(curRef), 0);
    busVolt = 8'd255;
    @(negedge clk);
    check("R10 one edge later still old", int'(curRef), 0);
    @(negedge clk);
    check("R10 two edges later updated", int'(curRef), (1916 * 255 + 128) >> 8);

    // R5: negative law output floors at zero, integrator at its lower clamp
    shapeSel = 2'd0; speedSet = 12'd0;
    for (int k = 0; k < 12; k++) strobe(1111);
    check("R5 negative output floors to zero", int'(curRef), 0);
    check("R5 model agreement", int'(curRef), magM);
    speedSet = 12'd1600;
    strobe(1111);
    check("R4 recovery from lower clamp", int'(curRef), magM);

    // R3: stall drives speed to zero, demand follows the full setpoint
    hallPer = 0; speedSet = 12'd100;
    repeat (TOUT + 2000) @(negedge clk);
    strobe(0);
    check("R3 stalled rotor speed reads zero", int'(curRef), magM);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule